// File: doc/BRIEF.md
# Write-back set-associative data cache with not-recently-used eviction

This block is a small data cache placed between a processor load/store port and a lower memory port. It uses a write-back policy. Each word-aligned request picks one set through its index bits. The request tag is then compared with the stored tag of every way of that set in parallel. A hit is served inside the cache. A store hit only marks its way dirty, and lower memory is not touched.

On a miss the cache picks a victim and handles the lower port. If the victim holds modified data, that word is written back first. The missing word is then read, installed and returned. The processor port holds its ready signal low from the moment a request is accepted until the response cycle has ended. Both lower-port requests use a valid/ready handshake.

Replacement is not-recently-used. Each way carries a used bit and a dirty bit. Together they form a two-bit keep priority, and the way with the smallest priority is evicted. All used bits are wiped after a fixed number of lookups, so only recent activity counts.

Top module: `nru_wb_cache`

## Requirements
- R1: With the default parameters a block is one 32-bit word. Address bits [4:2] select one of 8 sets, bits [31:5] form the tag, and a word may occupy any of the 4 ways of its set. The same tag in a different set is a different block.
- R2: A load hit returns the cached word and makes no lower-memory request. A store hit writes the word into the cache, and its response carries the stored word on cpu_resp_rdata.
- R3: On a load miss the cache issues one read (mem_req_write=0) to the word-aligned request address and returns the word delivered on mem_resp_rdata. On a store miss the cache reads the word, installs it, overwrites it with the store data and marks it dirty.
- R4: If the selected set has an invalid way, the lowest-numbered invalid way receives the new block, and nothing is written back.
- R5: If all ways are valid, the victim is the way with the smallest keep priority {used,dirty}: 0 unused clean, 1 unused dirty, 2 used clean, 3 used dirty. Ties go to the lowest-numbered way.
- R6: A way's used bit is set whenever it is hit or filled.
- R7: Every CLR_INTERVAL-th lookup (default 16) clears the used bits of all sets. When that lookup is itself a hit, its own used bit is set after the clear.
- R8: Stores never reach lower memory directly. An evicted dirty way is written to lower memory (mem_req_write=1, address {stored tag, index, 2'b00}, its data) before the refill read is issued. A clean victim is dropped silently.
- R9: While mem_req_valid is high and mem_req_ready is low, mem_req_valid, mem_req_addr, mem_req_write and mem_req_wdata hold. The cache issues no lower-memory request while cpu_req_ready is high.
- R10: After reset all ways are invalid, clean and unused. cpu_req_ready is high, and cpu_resp_valid and mem_req_valid are low.
- R11: Each accepted request yields exactly one single-cycle cpu_resp_valid pulse. cpu_req_ready is low from the cycle after acceptance through the response cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req_valid | input | 1 | Processor request present |
| cpu_req_ready | output | 1 | Cache can accept a request |
| cpu_req_write | input | 1 | 1 = store, 0 = load |
| cpu_req_addr | input | 32 | Byte address |
| cpu_req_wdata | input | 32 | Store data |
| cpu_resp_valid | output | 1 | One-cycle response strobe |
| cpu_resp_rdata | output | 32 | Loaded word, or stored word for stores |
| mem_req_valid | output | 1 | Lower-memory request present |
| mem_req_ready | input | 1 | Lower memory accepts the request |
| mem_req_write | output | 1 | 1 = write-back, 0 = refill read |
| mem_req_addr | output | 32 | Word-aligned lower-memory address |
| mem_req_wdata | output | 32 | Write-back data |
| mem_resp_valid | input | 1 | Refill data present |
| mem_resp_rdata | input | 32 | Refill data |

## Verification
The hardest situation to reach is a set whose used bits were just wiped by the interval clear while several ways are dirty. Only from that state can eviction show the order unused-clean, then unused-dirty, then used. It also shows that the lookup causing the clear keeps its own used bit.

The stimulus fills one set and dirties chosen ways. It then pads the lookup count with traffic to another set, so that a store hit in the target set lands exactly on the clearing lookup. The next misses expose each victim through the presence, address and data of write-backs, and through which later loads need a refill.

// File: rtl/nru_wb_cache.sv
module nru_wb_cache #(
  parameter int WAYS         = 4,
  parameter int SETS         = 8,
  parameter int ADDR_W       = 32,
  parameter int DATA_W       = 32,
  parameter int CLR_INTERVAL = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req_valid,
  output logic              cpu_req_ready,
  input  logic              cpu_req_write,
  input  logic [ADDR_W-1:0] cpu_req_addr,
  input  logic [DATA_W-1:0] cpu_req_wdata,
  output logic              cpu_resp_valid,
  output logic [DATA_W-1:0] cpu_resp_rdata,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic              mem_req_write,
  output logic [ADDR_W-1:0] mem_req_addr,
  output logic [DATA_W-1:0] mem_req_wdata,
  input  logic              mem_resp_valid,
  input  logic [DATA_W-1:0] mem_resp_rdata
);
  localparam int OFF_W = $clog2(DATA_W / 8);
  localparam int IDX_W = $clog2(SETS);
  localparam int TAG_W = ADDR_W - IDX_W - OFF_W;
  localparam int WAY_W = $clog2(WAYS);
  localparam int CNT_W = $clog2(CLR_INTERVAL) + 1;

  typedef enum logic [2:0] {S_IDLE, S_LOOK, S_WB, S_RFQ, S_RFW, S_RESP} state_t;

  state_t            st;
  logic [ADDR_W-1:0] r_addr;
  logic              r_wr;
  logic [DATA_W-1:0] r_wdata, r_rdata;
  logic [WAY_W-1:0]  vic_q;
  logic [CNT_W-1:0]  acc_cnt;

  logic [TAG_W-1:0]  tag_q  [SETS][WAYS];
  logic [DATA_W-1:0] data_q [SETS][WAYS];
  logic [WAYS-1:0]   vld_q [SETS];
  logic [WAYS-1:0]   dty_q [SETS];
  logic [WAYS-1:0]   use_q [SETS];

  wire [IDX_W-1:0] idx = r_addr[OFF_W +: IDX_W];
  wire [TAG_W-1:0] tag = r_addr[ADDR_W-1 -: TAG_W];

  logic [WAYS-1:0]  hit_vec;
  logic [WAY_W-1:0] hit_way, vic;
  logic             hit;

  always_comb begin
    hit_way = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      hit_vec[w] = vld_q[idx][w] && (tag_q[idx][w] == tag);
      if (hit_vec[w]) hit_way = WAY_W'(w);
    end
    hit = |hit_vec;
  end

  always_comb begin
    logic       inv_found, have;
    logic [1:0] best_p, p;
    logic [WAY_W-1:0] inv_way, best_way;
    inv_found = 1'b0; have = 1'b0;
    best_p = 2'd3; inv_way = '0; best_way = '0;
    for (int w = 0; w < WAYS; w++) begin
      p = {use_q[idx][w], dty_q[idx][w]};
      if (!vld_q[idx][w] && !inv_found) begin
        inv_found = 1'b1;
        inv_way   = WAY_W'(w);
      end
      if (!have || p < best_p) begin
        have     = 1'b1;
        best_p   = p;
        best_way = WAY_W'(w);
      end
    end
    vic = inv_found ? inv_way : best_way;
  end

  wire look_hit = (st == S_LOOK) && hit;
  wire fill     = (st == S_RFW) && mem_resp_valid;
  wire [DATA_W-1:0] fill_word = r_wr ? r_wdata : mem_resp_rdata;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      r_addr  <= '0;
      r_wr    <= 1'b0;
      r_wdata <= '0;
      r_rdata <= '0;
      vic_q   <= '0;
      acc_cnt <= '0;
      for (int s = 0; s < SETS; s++) begin
        vld_q[s] <= '0;
        dty_q[s] <= '0;
        use_q[s] <= '0;
      end
    end else begin
      case (st)
        S_IDLE: if (cpu_req_valid) begin
          r_addr  <= cpu_req_addr;
          r_wr    <= cpu_req_write;
          r_wdata <= cpu_req_wdata;
          st      <= S_LOOK;
        end
        S_LOOK: begin
          if (acc_cnt == CNT_W'(CLR_INTERVAL - 1)) begin
            acc_cnt <= '0;
            for (int s = 0; s < SETS; s++) use_q[s] <= '0;
          end else begin
            acc_cnt <= acc_cnt + 1'b1;
          end
          if (hit) begin
            use_q[idx][hit_way] <= 1'b1;
            if (r_wr) dty_q[idx][hit_way] <= 1'b1;
            r_rdata <= r_wr ? r_wdata : data_q[idx][hit_way];
            st      <= S_RESP;
          end else begin
            vic_q <= vic;
            st    <= (vld_q[idx][vic] && dty_q[idx][vic]) ? S_WB : S_RFQ;
          end
        end
        S_WB:  if (mem_req_ready) st <= S_RFQ;
        S_RFQ: if (mem_req_ready) st <= S_RFW;
        S_RFW: if (mem_resp_valid) begin
          vld_q[idx][vic_q] <= 1'b1;
          use_q[idx][vic_q] <= 1'b1;
          dty_q[idx][vic_q] <= r_wr;
          r_rdata           <= fill_word;
          st                <= S_RESP;
        end
        S_RESP: st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (look_hit && r_wr) data_q[idx][hit_way] <= r_wdata;
    if (fill) begin
      data_q[idx][vic_q] <= fill_word;
      tag_q[idx][vic_q]  <= tag;
    end
  end

  assign cpu_req_ready  = (st == S_IDLE);
  assign cpu_resp_valid = (st == S_RESP);
  assign cpu_resp_rdata = r_rdata;
  assign mem_req_valid  = (st == S_WB) || (st == S_RFQ);
  assign mem_req_write  = (st == S_WB);
  assign mem_req_addr   = (st == S_WB) ? {tag_q[idx][vic_q], idx, {OFF_W{1'b0}}}
                                       : {r_addr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
  assign mem_req_wdata  = data_q[idx][vic_q];
endmodule

// File: rtl/nru_wb_cache_chk.sv
module nru_wb_cache_chk #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cpu_req_valid,
  input logic              cpu_req_ready,
  input logic              cpu_resp_valid,
  input logic              mem_req_valid,
  input logic              mem_req_ready,
  input logic              mem_req_write,
  input logic [ADDR_W-1:0] mem_req_addr,
  input logic [DATA_W-1:0] mem_req_wdata
);
  p_mem_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr)
      && $stable(mem_req_write) && $stable(mem_req_wdata));

  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_req_ready |-> !mem_req_valid);

  p_wb_then_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && mem_req_ready && mem_req_write |=> mem_req_valid && !mem_req_write);

  p_resp_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_resp_valid |=> !cpu_resp_valid);

  p_stall_r11: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_req_valid && cpu_req_ready |=> !cpu_req_ready);

  p_resp_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_resp_valid |-> !cpu_req_ready);
endmodule

bind nru_wb_cache nru_wb_cache_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) chk_i (.*);

// File: tb/nru_wb_cache_tb_top.sv
module nru_wb_cache_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpu_req_valid = 1'b0, cpu_req_write = 1'b0;
  logic [31:0] cpu_req_addr = '0, cpu_req_wdata = '0;
  logic        cpu_req_ready, cpu_resp_valid;
  logic [31:0] cpu_resp_rdata;
  logic        mem_req_valid, mem_req_write;
  logic [31:0] mem_req_addr, mem_req_wdata;
  logic        mem_req_ready = 1'b0, mem_resp_valid = 1'b0;
  logic [31:0] mem_resp_rdata = '0;

  always #4 clk = ~clk;

  nru_wb_cache dut_i (.*);

  int n_chk = 0, n_fail = 0, resp_seen = 0, refill_cnt = 0, wb_cnt = 0;
  bit done = 1'b0;
  logic [31:0] last_wb_addr = '0, last_wb_data = '0;
  logic [31:0] mem [logic [31:0]];
  logic [31:0] exp_q [$];
  string       req_q [$];

  function automatic logic [31:0] pat(input logic [31:0] a);
    return {a[15:0], ~a[15:0]};
  endfunction

  function automatic logic [31:0] A(input int t, input int s = 0);
    return 32'(t * 32 + s * 4);
  endfunction

  function automatic logic [31:0] mem_rd(input logic [31:0] a);
    return mem.exists(a) ? mem[a] : pat(a);
  endfunction

  task automatic check(input string r, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", r, got, exp);
    end
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  // lower memory model: holds ready low one cycle on every request
  initial begin
    forever begin
      @(negedge clk);
      if (mem_req_valid && rst_n) begin
        logic        w;
        logic [31:0] a, d;
        @(negedge clk);
        mem_req_ready = 1'b1;
        w = mem_req_write; a = mem_req_addr; d = mem_req_wdata;
        @(negedge clk);
        mem_req_ready = 1'b0;
        if (w) begin
          mem[a] = d; wb_cnt++; last_wb_addr = a; last_wb_data = d;
        end else begin
          refill_cnt++;
          mem_resp_valid = 1'b1;
          mem_resp_rdata = mem_rd(a);
          @(negedge clk);
          mem_resp_valid = 1'b0;
        end
      end
    end
  end

  // response monitor: pops the scoreboard
  initial begin
    forever begin
      @(negedge clk);
      if (cpu_resp_valid) begin
        if (exp_q.size() == 0) begin
          check("R11 unexpected response", 32'd1, 32'd0);
        end else begin
          logic [31:0] e;
          string r;
          e = exp_q.pop_front();
          r = req_q.pop_front();
          check(r, cpu_resp_rdata, e);
        end
        resp_seen++;
      end
    end
  end

  task automatic access(input bit wr, input logic [31:0] a, input logic [31:0] d,
                        input logic [31:0] exp, input int exp_miss, input int exp_wb,
                        input logic [31:0] exp_wba, input logic [31:0] exp_wbd,
                        input string r);
    int rc0, wc0, n0;
    rc0 = refill_cnt; wc0 = wb_cnt; n0 = resp_seen;
    exp_q.push_back(exp);
    req_q.push_back({r, " data"});
    @(negedge clk);
    while (!cpu_req_ready) @(negedge clk);
    cpu_req_valid = 1'b1; cpu_req_write = wr; cpu_req_addr = a; cpu_req_wdata = d;
    @(negedge clk);
    cpu_req_valid = 1'b0;
    check("R11 ready low after accept", {31'd0, cpu_req_ready}, 32'd0);
    while (resp_seen == n0) @(posedge clk);
    @(negedge clk);
    check({r, " refill count"}, 32'(refill_cnt - rc0), 32'(exp_miss));
    check({r, " writeback count"}, 32'(wb_cnt - wc0), 32'(exp_wb));
    if (exp_wb != 0) begin
      check({r, " writeback addr"}, last_wb_addr, exp_wba);
      check({r, " writeback data"}, last_wb_data, exp_wbd);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    check("watchdog expired", 32'd1, 32'd0);
    finish_up();
  end

  localparam logic [31:0] X = 32'hCAFE_0004, Y = 32'hBEEF_0002;
  localparam logic [31:0] Z = 32'h1234_0003, W = 32'h7777_0004;

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    check("R10 ready after reset", {31'd0, cpu_req_ready}, 32'd1);
    check("R10 no response after reset", {31'd0, cpu_resp_valid}, 32'd0);
    check("R10 no mem request after reset", {31'd0, mem_req_valid}, 32'd0);
    // R4 / R10: empty set fills ways 0..3 without any write-back
    access(0, A(1), 0, pat(A(1)), 1, 0, 0, 0, "R4 R3 load miss A1");
    access(0, A(2), 0, pat(A(2)), 1, 0, 0, 0, "R4 load miss A2");
    access(0, A(3), 0, pat(A(3)), 1, 0, 0, 0, "R4 load miss A3");
    access(1, A(4), X, X, 1, 0, 0, 0, "R3 store miss A4");
    access(0, A(1), 0, pat(A(1)), 0, 0, 0, 0, "R2 load hit A1");
    access(1, A(2), Y, Y, 0, 0, 0, 0, "R2 R8 store hit A2");
    // priorities: w0=2 w1=3 w2=2 w3=3 -> clean way 0
    access(0, A(5), 0, pat(A(5)), 1, 0, 0, 0, "R5 clean victim way0");
    access(0, A(1), 0, pat(A(1)), 1, 0, 0, 0, "R5 evicted block misses");
    // R1: same tag in set 1 is a different block; pad lookups to 15
    access(0, A(1, 1), 0, pat(A(1, 1)), 1, 0, 0, 0, "R1 other set miss");
    for (int i = 0; i < 6; i++)
      access(0, A(1, 1), 0, pat(A(1, 1)), 0, 0, 0, 0, "R1 other set hit");
    // 16th lookup: clear, then this hit re-marks way2 (R7)
    access(1, A(3), Z, Z, 0, 0, 0, 0, "R7 store hit on clearing lookup");
    // w0=0 w1=1 w2=3 w3=1
    access(0, A(6), 0, pat(A(6)), 1, 0, 0, 0, "R7 R5 unused clean first");
    access(0, A(7), 0, pat(A(7)), 1, 1, A(2), Y, "R8 R5 unused dirty way1 written back");
    access(0, A(2), 0, Y, 1, 1, A(4), X, "R7 R8 way3 not way2 evicted");
    access(0, A(4), 0, X, 1, 0, 0, 0, "R6 R5 used clean way0");
    access(1, A(4), W, W, 0, 0, 0, 0, "R2 store hit A4");
    // w0=3 w1=2 w2=3 w3=2 -> way1 despite lower way0
    access(0, A(8), 0, pat(A(8)), 1, 0, 0, 0, "R5 dirty kept over clean");
    access(0, A(4), 0, W, 0, 0, 0, 0, "R5 dirty way0 still hit");
    access(0, A(3), 0, Z, 0, 0, 0, 0, "R2 dirty way2 still hit");
    access(0, A(1, 1), 0, pat(A(1, 1)), 0, 0, 0, 0, "R1 set1 untouched");
    repeat (4) @(negedge clk);
    check("R11 scoreboard drained", 32'(exp_q.size()), 32'd0);
    finish_up();
  end
endmodule